// File: doc/BRIEF.md
# Paired-Mask GPIO Bank Controller

This block controls 32 general-purpose pins through a small synchronous register bus. The pins are split into a low bank (pins 0 to 15) and a high bank (pins 16 to 31). Each bank has six per-pin configuration registers: drive level, drive enable, open-drain select, pull-up, pull-down and input enable. The block also has a read-only view of the pin inputs after a synchronizer, and a read-only view of the drive levels.

No register is ever written with its plain contents. Every write carries a paired mask. A 1 in the lower half of the data raises the matching register bit. A 1 in the upper half lowers it. Bits with a 0 in both halves keep their value. Software can therefore change single pins with no read-modify-write and no lock.

The pad-facing outputs come straight from the register state. They give a drive level, a drive enable and a pull-up and pull-down request for every pin.

Top module: `gpio_pair_bank`

## Requirements
- R1: After reset all configuration registers are 0. pad_oe, pad_out, pad_pu and pad_pd are all 0, and every mapped read returns 0.
- R2: Address bit 7 selects the bank: 0x00 to 0x7F is the low bank (pins 0-15), 0x80 to 0xFF is the high bank (pins 16-31). Register bit n of a bank controls pin n of the low bank or pin n+16 of the high bank.
- R3: A write sets register bit n (n = 0..15) when wdata[n] is 1 and clears it when wdata[n+16] is 1. All other bits are unchanged.
- R4: When wdata[n] and wdata[n+16] are both 1 in the same write, bit n becomes 0.
- R5: Bank-relative offsets: drive enable 0x04, open-drain 0x08, pull-up 0x18, pull-down 0x1C and input enable 0x20 are both written and read at that offset. The drive level is written at 0x00 and read at 0x30. A read of 0x00 returns 0.
- R6: A read is captured into rdata at the clock edge where rd_en is 1. rdata keeps its value while rd_en is 0. rdata[31:16] is always 0.
- R7: Writes to any other bank-relative offset change nothing, including offsets that are not multiples of 4. Reads of any other offset return 0.
- R8: pad_pu and pad_pd follow the pull-up and pull-down registers. pad_out is the drive level AND NOT open-drain. pad_oe is the drive enable, except that it is 0 when open-drain is set and the drive level is 1.
- R9: A read at bank-relative 0x34 returns the pin inputs AND the input-enable bits. Each pin passes through a two-flop synchronizer: a pin change made after clock edge k first reaches rdata with a read captured at edge k+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Byte address in the 256-byte window |
| wdata | input | 32 | Paired set/clear mask |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pin input levels |
| pad_out | output | 32 | Drive level per pin |
| pad_oe | output | 32 | Drive enable per pin |
| pad_pu | output | 32 | Pull-up request per pin |
| pad_pd | output | 32 | Pull-down request per pin |

## Verification
The hardest case to reach is the synchronizer latency on the input view. A read made one cycle after a pin change must still return the old level, and only the next read returns the new one. The bench changes pin_in right after a falling edge and reads at once, so the read is captured while the second flop still holds the old value. It then reads again and expects the new level. A second hard case is the open-drain release: pad_oe must drop only for pins whose drive level is 1. The bench sets up a mixed pattern of level, enable and open-drain bits so that all four combinations occur in one bank at the same time.

// File: rtl/gpio_pair_bank.sv
module gpio_pair_bank #(
  parameter int PINS = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  input  logic            wr_en,
  input  logic            rd_en,
  output logic [31:0]     rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_pu,
  output logic [PINS-1:0] pad_pd
);
  localparam int BW = PINS / 2;
  localparam int OW = AW - 1;

  localparam logic [OW-1:0] OFS_LVL = OW'('h00);
  localparam logic [OW-1:0] OFS_OE  = OW'('h04);
  localparam logic [OW-1:0] OFS_OD  = OW'('h08);
  localparam logic [OW-1:0] OFS_PU  = OW'('h18);
  localparam logic [OW-1:0] OFS_PD  = OW'('h1C);
  localparam logic [OW-1:0] OFS_IE  = OW'('h20);
  localparam logic [OW-1:0] OFS_RB  = OW'('h30);
  localparam logic [OW-1:0] OFS_IN  = OW'('h34);

  logic [1:0][BW-1:0] lvl, oe, od, pu, pd, ie;
  logic [PINS-1:0]    sync1, sync2;
  logic [BW-1:0]      rd_word;

  wire           bank = addr[AW-1];
  wire [OW-1:0]  ofs  = addr[OW-1:0];
  wire [BW-1:0]  set_m = wdata[BW-1:0];
  wire [BW-1:0]  clr_m = wdata[2*BW-1:BW];
  wire           wr_hit = (ofs == OFS_LVL) || (ofs == OFS_OE) || (ofs == OFS_OD) ||
                          (ofs == OFS_PU)  || (ofs == OFS_PD) || (ofs == OFS_IE);

  function automatic logic [BW-1:0] upd(input logic [BW-1:0] cur,
                                        input logic [BW-1:0] s,
                                        input logic [BW-1:0] c);
    return (cur | s) & ~c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl <= '0; oe <= '0; od <= '0; pu <= '0; pd <= '0; ie <= '0;
    end else if (wr_en) begin
      case (ofs)
        OFS_LVL: lvl[bank] <= upd(lvl[bank], set_m, clr_m);
        OFS_OE:  oe[bank]  <= upd(oe[bank],  set_m, clr_m);
        OFS_OD:  od[bank]  <= upd(od[bank],  set_m, clr_m);
        OFS_PU:  pu[bank]  <= upd(pu[bank],  set_m, clr_m);
        OFS_PD:  pd[bank]  <= upd(pd[bank],  set_m, clr_m);
        OFS_IE:  ie[bank]  <= upd(ie[bank],  set_m, clr_m);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  wire [1:0][BW-1:0] in_view = sync2 & ie;

  always_comb begin
    case (ofs)
      OFS_OE:  rd_word = oe[bank];
      OFS_OD:  rd_word = od[bank];
      OFS_PU:  rd_word = pu[bank];
      OFS_PD:  rd_word = pd[bank];
      OFS_IE:  rd_word = ie[bank];
      OFS_RB:  rd_word = lvl[bank];
      OFS_IN:  rd_word = in_view[bank];
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= {{(32-BW){1'b0}}, rd_word};
  end

  assign pad_pu  = pu;
  assign pad_pd  = pd;
  assign pad_out = lvl & ~od;
  assign pad_oe  = oe & ~(od & lvl);

  // R4
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ofs == OFS_OE) |=> ((oe[$past(bank)] & $past(clr_m)) == '0));

  // R3
  set_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ofs == OFS_PU) |=>
      ((pu[$past(bank)] & $past(set_m) & ~$past(clr_m)) == ($past(set_m) & ~$past(clr_m))));

  // R7
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || !wr_hit) |=> $stable({lvl, oe, od, pu, pd, ie}));

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[31:BW] == '0);

  // R6
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R5
  level_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ofs == OFS_RB) |=> rdata[BW-1:0] == $past(lvl[bank]));
endmodule

// File: tb/sim_gpio_pair_bank.sv
module sim_gpio_pair_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [31:0] rdata;
  logic [31:0] pin_in = 0;
  logic [31:0] pad_out, pad_oe, pad_pu, pad_pd;
  int checks = 0, failures = 0;
  logic [31:0] v;

  gpio_pair_bank u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd));

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic clear_all();
    logic [7:0] offs [6] = '{8'h00, 8'h04, 8'h08, 8'h18, 8'h1C, 8'h20};
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 6; i++) wr(offs[i] | 8'(b * 8'h80), 32'hFFFF_0000);
  endtask

  task automatic t_reset();
    logic [7:0] offs [8] = '{8'h00, 8'h04, 8'h08, 8'h18, 8'h1C, 8'h20, 8'h30, 8'h34};
    check("R1 pad_oe", pad_oe, 0);
    check("R1 pad_out", pad_out, 0);
    check("R1 pad_pu", pad_pu, 0);
    check("R1 pad_pd", pad_pd, 0);
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 8; i++) begin
        rd(offs[i] | 8'(b * 8'h80), v);
        check("R1 read", v, 0);
      end
  endtask

  task automatic t_setclr();
    wr(8'h04, 32'h0000_00F0); rd(8'h04, v); check("R3 set", v, 32'h00F0);
    wr(8'h04, 32'h0030_0001); rd(8'h04, v); check("R3 set+clear", v, 32'h00C1);
    check("R8 oe pads", pad_oe, 32'h0000_00C1);
    wr(8'h04, 32'h0); rd(8'h04, v); check("R3 zero mask", v, 32'h00C1);
    clear_all();
  endtask

  task automatic t_both();
    wr(8'h18, 32'h0000_0001);
    wr(8'h18, 32'h0001_0001); rd(8'h18, v); check("R4 same bit", v, 0);
    wr(8'h18, 32'h0002_0006); rd(8'h18, v); check("R4 mixed", v, 32'h0004);
    check("R4 pad_pu", pad_pu, 32'h0000_0004);
    clear_all();
  endtask

  task automatic t_bank();
    wr(8'h98, 32'h0000_0003);
    check("R2 high pu pads", pad_pu, 32'h0003_0000);
    rd(8'h18, v); check("R2 low untouched", v, 0);
    rd(8'h98, v); check("R2 high read", v, 32'h0003);
    wr(8'h9C, 32'h0000_8000);
    check("R2 pin31 pd", pad_pd, 32'h8000_0000);
    clear_all();
  endtask

  task automatic t_offsets();
    wr(8'h00, 32'h1111); wr(8'h04, 32'h2222); wr(8'h08, 32'h4444);
    wr(8'h18, 32'h1010); wr(8'h1C, 32'h8888); wr(8'h20, 32'h0101);
    rd(8'h04, v); check("R5 oe", v, 32'h2222);
    rd(8'h08, v); check("R5 od", v, 32'h4444);
    rd(8'h18, v); check("R5 pu", v, 32'h1010);
    rd(8'h1C, v); check("R5 pd", v, 32'h8888);
    rd(8'h20, v); check("R5 ie", v, 32'h0101);
    rd(8'h30, v); check("R5 level readback", v, 32'h1111);
    rd(8'h00, v); check("R5 write-only 0x00", v, 0);
    clear_all();
  endtask

  task automatic t_pad();
    wr(8'h00, 32'h0005); wr(8'h04, 32'h000F); wr(8'h08, 32'h000C);
    check("R8 pad_out", pad_out, 32'h0000_0001);
    check("R8 pad_oe", pad_oe, 32'h0000_000B);
    clear_all();
  endtask

  task automatic t_unmapped();
    wr(8'h0C, 32'h0000_FFFF); wr(8'h40, 32'h0000_FFFF); wr(8'h05, 32'h0000_FFFF);
    wr(8'hB0, 32'h0000_FFFF);
    check("R7 pads oe", pad_oe | pad_out | pad_pu | pad_pd, 0);
    rd(8'h0C, v); check("R7 read 0x0C", v, 0);
    rd(8'h05, v); check("R7 read misaligned", v, 0);
    rd(8'h04, v); check("R7 oe untouched", v, 0);
    rd(8'h30, v); check("R7 level untouched", v, 0);
    rd(8'hB0, v); check("R7 high level untouched", v, 0);
  endtask

  task automatic t_read_hold();
    wr(8'h30, 32'h0000_FFFF);
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h30, v); check("R6 upper half zero", v, 0);
    wr(8'h04, 32'h00AB); rd(8'h04, v); check("R6 read", v, 32'h0000_00AB);
    wr(8'h04, 32'h00FF_0000);
    @(negedge clk); check("R6 hold", rdata, 32'h0000_00AB);
    clear_all();
  endtask

  task automatic t_input();
    @(negedge clk); pin_in = 32'h0005_0003;
    repeat (3) @(negedge clk);
    rd(8'h34, v); check("R9 gated off", v, 0);
    wr(8'h20, 32'h0000_FFFF);
    rd(8'h34, v); check("R9 low bank", v, 32'h0003);
    wr(8'hA0, 32'h0000_0004);
    rd(8'hB4, v); check("R9 high bank gated", v, 32'h0004);
    pin_in = 32'h0;
    rd(8'h34, v); check("R9 sync latency old", v, 32'h0003);
    rd(8'h34, v); check("R9 sync latency new", v, 0);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_setclr();
    t_both();
    t_bank();
    t_offsets();
    t_pad();
    t_unmapped();
    t_read_hold();
    t_input();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule